// File: doc/BRIEF.md
# Registered Read Return Multiplexer with Data Hold

This block gathers the read responses of several peripheral slaves and turns them into one read response for a bus master. Each slave has its own data lane and its own acknowledge. On every clock edge the block picks the acknowledging slave with the lowest index and captures that slave's data into an output register. The acknowledge is registered alongside it, so the master sees the data and the acknowledge in the same cycle, one clock after the slave raised them.

When no slave acknowledges, the output data register keeps whatever it last captured instead of falling to zero. The master's read bus therefore stays steady through the idle cycles between accesses to different slaves. Every stage is registered, so a wide return path can be built as a tree. The output of one instance is wired as one slave lane of the next instance, and each level adds exactly one cycle. The slave count and the data width are parameters.

Top module: `read_hold_mux`

## Requirements
- R1: While the active-low reset `rstN` is low, `mstAck` is 0 and `mstData` is all zeros, whatever the slave inputs are.
- R2: When exactly one slave k raises its acknowledge at a clock edge, the data on lane k (bits k*DW to k*DW+DW-1 of `slvData`) at that edge appears on `mstData` after that edge. This is one cycle of latency.
- R3: `mstAck` is high in the cycle after any slave acknowledge was high at the clock edge, which is the same cycle in which the captured data is on `mstData`.
- R4: When several slave acknowledges are high at the same edge, the data of the lowest-numbered acknowledging slave is captured.
- R5: When no slave acknowledge is high at a clock edge, `mstData` keeps its previous value across that edge and does not go to zero.
- R6: `mstAck` is low in the cycle after an edge at which every slave acknowledge was low.
- R7: Data lanes of slaves whose acknowledge is low have no effect on `mstData`, both during idle cycles and while another slave acknowledges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| slvData | input | N*DW | Concatenated slave read data lanes; lane k in bits k*DW +: DW |
| slvAck | input | N | Per-slave read acknowledge, bit k for slave k |
| mstData | output | DW | Registered read data toward the master, held between accesses |
| mstAck | output | 1 | Registered acknowledge toward the master |

## Verification
The bench targets the idle cycles that follow an acknowledge. It changes every data lane during those cycles, so a design that cleared the register or kept loading a lane would show a changed `mstData`. It raises several acknowledges together, with slave 0 and without it, to catch a priority encoder that favours the highest index. It runs back-to-back acknowledges from different slaves and single-cycle acknowledges, where an acknowledge registered one cycle off from its data, or one held one cycle too long, would show up as a mismatch on `mstAck`.

// File: rtl/read_hold_mux_pkg.sv
package read_hold_mux_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic loadData;   // capture the selected lane at this edge
    logic ackNext;    // value the master acknowledge takes after this edge
  } muxStrobes_t;

  function automatic int selWidth(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/read_hold_mux_ctrl.sv
module read_hold_mux_ctrl
  import read_hold_mux_pkg::*;
#(
  parameter int N     = 4,
  parameter int SEL_W = selWidth(N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     slvAck,
  output muxStrobes_t      strobes,
  output logic [SEL_W-1:0] selIdx,
  output logic             ackReg
);

  // Lowest index wins: scan downward so the last hit is the smallest index.
  always_comb begin
    selIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (slvAck[i]) selIdx = i[SEL_W-1:0];
    end
  end

  always_comb begin
    strobes.loadData = |slvAck;
    strobes.ackNext  = |slvAck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackReg <= 1'b0;
    else       ackReg <= strobes.ackNext;
  end

endmodule

// File: rtl/read_hold_mux_dp.sv
module read_hold_mux_dp
  import read_hold_mux_pkg::*;
#(
  parameter int N     = 4,
  parameter int DW    = 16,
  parameter int SEL_W = selWidth(N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N*DW-1:0]  slvData,
  input  muxStrobes_t      strobes,
  input  logic [SEL_W-1:0] selIdx,
  output logic [DW-1:0]    holdReg
);

  logic [DW-1:0] lane [N];
  logic [DW-1:0] selData;

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign lane[g] = slvData[g*DW +: DW];
  end

  assign selData = lane[selIdx];

  // Register only loads on an acknowledge; otherwise the bus value is held.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 holdReg <= '0;
    else if (strobes.loadData) holdReg <= selData;
  end

endmodule

// File: rtl/read_hold_mux.sv
module read_hold_mux
  import read_hold_mux_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N*DW-1:0] slvData,
  input  logic [N-1:0]  slvAck,
  output logic [DW-1:0] mstData,
  output logic          mstAck
);

  localparam int SEL_W = selWidth(N);

  muxStrobes_t      strobes;
  logic [SEL_W-1:0] selIdx;

  read_hold_mux_ctrl #(.N(N), .SEL_W(SEL_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .slvAck  (slvAck),
    .strobes (strobes),
    .selIdx  (selIdx),
    .ackReg  (mstAck)
  );

  read_hold_mux_dp #(.N(N), .DW(DW), .SEL_W(SEL_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .slvData (slvData),
    .strobes (strobes),
    .selIdx  (selIdx),
    .holdReg (mstData)
  );

endmodule

// File: rtl/read_hold_mux_chk.sv
module read_hold_mux_chk #(
  parameter int N  = 4,
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic [N*DW-1:0] slvData,
  input logic [N-1:0]    slvAck,
  input logic [DW-1:0]   mstData,
  input logic            mstAck
);

  localparam logic [N-1:0] TOP_ONLY = N'(1) << (N - 1);

  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (|slvAck) |=> mstAck);                                        // R3

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !(|slvAck) |=> !mstAck);                                      // R6

  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(|slvAck) |=> $stable(mstData));                             // R5

  AST_LOW_INDEX_WINS: assert property (@(posedge clk) disable iff (!rstN)
    slvAck[0] |=> (mstData == $past(slvData[DW-1:0])));           // R4

  AST_TOP_LANE_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    (slvAck == TOP_ONLY) |=> (mstData == $past(slvData[N*DW-1 -: DW]))); // R2

endmodule

bind read_hold_mux read_hold_mux_chk #(.N(N), .DW(DW)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .slvData (slvData),
  .slvAck  (slvAck),
  .mstData (mstData),
  .mstAck  (mstAck)
);

// File: tb/read_hold_mux_bench.sv
`timescale 1ns/1ps
module read_hold_mux_bench;

  localparam int N  = 4;
  localparam int DW = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [N*DW-1:0] slvData = '0;
  logic [N-1:0]    slvAck = '0;
  logic [DW-1:0]   mstData;
  logic            mstAck;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  // Scoreboard queues, one entry per driven cycle.
  logic          expAckQ  [$];
  logic [DW-1:0] expDataQ [$];
  string         tagQ     [$];

  logic [DW-1:0] modelData = '0;

  always #10 clk = ~clk;   // 50 MHz

  read_hold_mux #(.N(N), .DW(DW)) u_read_hold_mux (
    .clk(clk), .rstN(rstN), .slvData(slvData), .slvAck(slvAck),
    .mstData(mstData), .mstAck(mstAck)
  );

  task automatic drive(input logic [N-1:0] ack,
                       input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                       input logic [DW-1:0] d2, input logic [DW-1:0] d3,
                       input string tag);
    logic [DW-1:0] lanes [N];
    @(negedge clk);
    lanes[0] = d0; lanes[1] = d1; lanes[2] = d2; lanes[3] = d3;
    slvAck  = ack;
    slvData = {d3, d2, d1, d0};
    for (int i = N - 1; i >= 0; i--) begin
      if (ack[i]) modelData = lanes[i];
    end
    expAckQ.push_back(|ack);
    expDataQ.push_back(modelData);
    tagQ.push_back(tag);
  endtask

  // Monitor: compare one expected item per edge, away from the edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expAckQ.size() > 0) begin
        logic          eAck;
        logic [DW-1:0] eData;
        string         t;
        eAck = expAckQ.pop_front();
        eData = expDataQ.pop_front();
        t = tagQ.pop_front();
        testsRun++;
        if (mstAck !== eAck || mstData !== eData) begin
          testsFailed++;
          $display("FAIL %s: actual ack=%0b data=%h expected ack=%0b data=%h",
                   t, mstAck, mstData, eAck, eData);
        end
      end
    end
  end

  initial begin
    // R1: reset holds outputs at zero even with acks and data applied
    slvAck  = '1;
    slvData = {16'hDEAD, 16'hBEEF, 16'hCAFE, 16'hF00D};
    repeat (3) @(posedge clk);
    #5;
    testsRun++;
    if (mstAck !== 1'b0 || mstData !== '0) begin
      testsFailed++;
      $display("FAIL R1: actual ack=%0b data=%h expected ack=0 data=0000", mstAck, mstData);
    end
    @(negedge clk);
    slvAck = '0;
    rstN = 1'b1;

    drive(4'b0000, 16'h1111, 16'h2222, 16'h3333, 16'h4444, "R1 idle after reset");
    drive(4'b0100, 16'h0001, 16'h0002, 16'hA5A5, 16'h0004, "R2 single slave 2");
    drive(4'b0000, 16'h9999, 16'h8888, 16'h7777, 16'h6666, "R5 hold after ack");
    drive(4'b0000, 16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF, "R7 idle lanes ignored");
    drive(4'b1001, 16'h1234, 16'h5555, 16'h6666, 16'hABCD, "R4 slaves 0 and 3");
    drive(4'b1010, 16'h0101, 16'h4321, 16'h0303, 16'h0404, "R4 slaves 1 and 3");
    drive(4'b1110, 16'h0000, 16'h7E7E, 16'h1F1F, 16'h2E2E, "R4 slaves 1,2,3");
    drive(4'b1000, 16'h0011, 16'h0022, 16'h0033, 16'hC0DE, "R2 single slave 3");
    drive(4'b0010, 16'h0000, 16'hB00B, 16'h0000, 16'h0000, "R3 back to back slave 1");
    drive(4'b0100, 16'h0000, 16'h0000, 16'hD00D, 16'h0000, "R3 back to back slave 2");
    drive(4'b0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, "R6 ack drops");
    drive(4'b0001, 16'h0000, 16'h1111, 16'h2222, 16'h3333, "R2 zero data slave 0");
    drive(4'b0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, "R5 hold zero value");
    drive(4'b0100, 16'hEEEE, 16'hDDDD, 16'h5A5A, 16'hBBBB, "R7 other lanes ignored");

    // Mixed deterministic patterns covering R2, R4, R5 and R6
    for (int k = 0; k < 48; k++) begin
      logic [N-1:0] a;
      a = (k % 3 == 0) ? 4'b0000 : N'((k * 7 + 3) % 16);
      drive(a, DW'(k * 97 + 1), DW'(k * 131 + 2), DW'(k * 211 + 3), DW'(k * 53 + 4),
            "R4 mixed pattern");
    end
    drive(4'b0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, "R6 final idle");

    @(posedge clk);
    #6;
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL R2 watchdog: actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule